// File: doc/BRIEF.md
# SPI Register-Access Slave Port

This block is a four-wire SPI slave that lets an external host read and write a bank of 128 eight-bit registers. All serial pins are brought into the system clock domain through synchronisers, and the edges of the serial clock are found inside the block. The system clock must run at least four times faster than the serial clock. On the register side the block presents a plain parallel interface: an address, write data with a one-cycle write strobe, and combinational read data returned by the register file.

Every transaction opens with a command byte. Its top bit chooses the direction and its lower seven bits give the first register address. Data bytes then follow for as long as chip select stays low. The address steps by one after each byte and wraps from the top of the bank back to zero. Serial data is taken in on rising serial-clock edges and sent out on falling edges, MSB first. The serial output is driven only during the data phase of a read; the pad driver uses the output-enable port.

Top module: `spi_regport`

## Requirements
- R1: While chip select (active low) is high, serial input is ignored: no write strobe is issued, no register changes, and the output enable stays low.
- R2: Bits are taken from the serial input on rising serial-clock edges and changed on the serial output after falling edges, MSB first.
- R3: The first byte after chip select falls is a command: bit 7 = 1 selects a write and bit 7 = 0 a read; bits 6..0 are the start address.
- R4: In a write, each fully received data byte produces exactly one write strobe of one system-clock cycle, carrying the current address and that byte, and only while chip select is low.
- R5: In a burst, the address rises by one after every data byte, for reads and for writes.
- R6: The address after 0x7F is 0x00.
- R7: A data byte cut short by chip select rising is discarded, and no register is updated.
- R8: In a read, the first data byte is the register at the start address. The output enable is high only in the data phase of a read, never in a write or during the command byte.
- R9: After reset the write strobe and the output enable are low and the address is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from the host, idle low |
| spi_csn | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| spi_miso_oe | output | 1 | Drive enable for the serial output pad |
| reg_addr | output | 7 | Register address |
| reg_wdata | output | 8 | Register write data |
| reg_we | output | 1 | One-cycle register write strobe |
| reg_rdata | input | 8 | Read data from the register file for reg_addr |

## Verification
The hardest case to reach is a byte cut short by chip select rising, and the closely related wrap of the address from 0x7F to 0x00 in the middle of a burst. The bench has a bit-level serial task that can stop after any number of bits, so it raises chip select after five data bits and then checks the strobe count and the register contents. It also starts bursts at 0x7E for both writes and reads, which drives the pointer across the wrap within a single transaction.

// File: rtl/spi_regport_pkg.sv
package spi_regport_pkg;
  typedef enum logic {
    PH_CMD  = 1'b0,
    PH_DATA = 1'b1
  } phase_t;
endpackage

// File: rtl/spi_regport_sync.sv
module spi_regport_sync #(
  parameter int WIDTH     = 3,
  parameter int STAGES    = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] q_out
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= RST_VAL;
      else if (s == 0) stage_q[s] <= d_in;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_out = stage_q[STAGES-1];
endmodule

// File: rtl/spi_regport_rx.sv
module spi_regport_rx #(
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act,
  input  logic              sclk_rise,
  input  logic              din,
  output logic              byte_done,
  output logic [DATA_W-1:0] byte_val
);
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [DATA_W-1:0] sr_q, sr_n;
  logic              en;

  assign en        = !cs_act || sclk_rise;
  assign byte_val  = {sr_q[DATA_W-2:0], din};
  assign byte_done = cs_act && sclk_rise && (cnt_q == CNT_W'(DATA_W-1));

  always_comb begin
    cnt_n = cnt_q;
    sr_n  = sr_q;
    if (!cs_act) begin
      cnt_n = '0;
      sr_n  = '0;
    end else if (sclk_rise) begin
      sr_n  = byte_val;
      cnt_n = byte_done ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sr_q  <= '0;
    end else if (en) begin
      cnt_q <= cnt_n;
      sr_q  <= sr_n;
    end
  end
endmodule

// File: rtl/spi_regport_tx.sv
module spi_regport_tx #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              load,
  input  logic [DATA_W-1:0] load_val,
  input  logic              shift,
  output logic              dout
);
  logic [DATA_W-1:0] sr_q, sr_n;
  logic              dout_q, dout_n;
  logic              en;

  assign en = clr || load || shift;

  always_comb begin
    sr_n   = sr_q;
    dout_n = dout_q;
    if (clr) begin
      sr_n   = '0;
      dout_n = 1'b0;
    end else if (load) begin
      sr_n = load_val;
    end else if (shift) begin
      dout_n = sr_q[DATA_W-1];
      sr_n   = {sr_q[DATA_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      dout_q <= 1'b0;
    end else if (en) begin
      sr_q   <= sr_n;
      dout_q <= dout_n;
    end
  end

  assign dout = dout_q;
endmodule

// File: rtl/spi_regport.sv
module spi_regport
  import spi_regport_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sclk,
  input  logic              spi_csn,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              spi_miso_oe,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              reg_we,
  input  logic [DATA_W-1:0] reg_rdata
);
  localparam int CMD_BIT = DATA_W - 1;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sr_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sr_q <= 2'b00;
    else        rst_sr_q <= {rst_sr_q[0], 1'b1};
  end
  assign rst_int_n = rst_sr_q[1];

  // pin synchronisers: {csn, sclk, mosi}
  logic [2:0] pins_s;
  logic       csn_s, sclk_s, mosi_s, sclk_d_q;
  spi_regport_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d_in  ({spi_csn, spi_sclk, spi_mosi}),
    .q_out (pins_s)
  );
  assign {csn_s, sclk_s, mosi_s} = pins_s;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) sclk_d_q <= 1'b0;
    else            sclk_d_q <= sclk_s;
  end

  logic cs_act, sclk_rise, sclk_fall;
  assign cs_act    = !csn_s;
  assign sclk_rise = sclk_s && !sclk_d_q;
  assign sclk_fall = !sclk_s && sclk_d_q;

  logic              byte_done;
  logic [DATA_W-1:0] byte_val;
  spi_regport_rx #(.DATA_W(DATA_W)) u_rx (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .cs_act    (cs_act),
    .sclk_rise (sclk_rise),
    .din       (mosi_s),
    .byte_done (byte_done),
    .byte_val  (byte_val)
  );

  // transaction control
  phase_t            phase_q, phase_n;
  logic              wr_q, wr_n;
  logic [ADDR_W-1:0] ptr_q, ptr_n;
  logic              we_q, we_n;
  logic [DATA_W-1:0] wdata_q, wdata_n;
  logic              load_q, load_n;

  always_comb begin
    phase_n = phase_q;
    wr_n    = wr_q;
    ptr_n   = ptr_q;
    we_n    = 1'b0;
    wdata_n = wdata_q;
    load_n  = 1'b0;
    if (we_q) ptr_n = ptr_q + 1'b1;
    if (!cs_act) begin
      phase_n = PH_CMD;
      wr_n    = 1'b0;
    end else if (byte_done) begin
      if (phase_q == PH_CMD) begin
        phase_n = PH_DATA;
        wr_n    = byte_val[CMD_BIT];
        ptr_n   = byte_val[ADDR_W-1:0];
        load_n  = !byte_val[CMD_BIT];
      end else if (wr_q) begin
        we_n    = 1'b1;
        wdata_n = byte_val;
      end else begin
        ptr_n  = ptr_q + 1'b1;
        load_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      phase_q <= PH_CMD;
      wr_q    <= 1'b0;
      ptr_q   <= '0;
      we_q    <= 1'b0;
      wdata_q <= '0;
      load_q  <= 1'b0;
    end else begin
      phase_q <= phase_n;
      wr_q    <= wr_n;
      ptr_q   <= ptr_n;
      we_q    <= we_n;
      wdata_q <= wdata_n;
      load_q  <= load_n;
    end
  end

  logic oe;
  assign oe = cs_act && (phase_q == PH_DATA) && !wr_q;

  spi_regport_tx #(.DATA_W(DATA_W)) u_tx (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .clr      (!cs_act),
    .load     (load_q),
    .load_val (reg_rdata),
    .shift    (sclk_fall && oe),
    .dout     (spi_miso)
  );

  assign spi_miso_oe = oe;
  assign reg_addr    = ptr_q;
  assign reg_wdata   = wdata_q;
  assign reg_we      = we_q;
endmodule

// File: rtl/spi_regport_chk.sv
module spi_regport_chk #(
  parameter int ADDR_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              csn_s,
  input logic              spi_miso_oe,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr
);
  a_r1_oe_off_after_cs: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(csn_s) |=> !spi_miso_oe);

  a_r4_we_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);

  a_r4_we_cs_low: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> $past(!csn_s));

  a_r5_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> reg_addr == ($past(reg_addr) + 1'b1));

  a_r8_oe_not_write: assert property (@(posedge clk) disable iff (!rst_n)
    spi_miso_oe |-> !reg_we);
endmodule

bind spi_regport spi_regport_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_int_n),
  .csn_s       (csn_s),
  .spi_miso_oe (spi_miso_oe),
  .reg_we      (reg_we),
  .reg_addr    (reg_addr)
);

// File: tb/spi_regport_tb.sv
module spi_regport_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sclk = 1'b0, csn = 1'b1, mosi = 1'b0;
  logic       miso, miso_oe, we;
  logic [6:0] addr;
  logic [7:0] wdata, rdata;
  logic [7:0] mem [128];
  int         n_run = 0, n_fail = 0, we_cnt = 0;
  logic       oe_seen;

  always #2.5 clk = ~clk;

  spi_regport u_dut (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_csn(csn), .spi_mosi(mosi),
    .spi_miso(miso), .spi_miso_oe(miso_oe), .reg_addr(addr), .reg_wdata(wdata),
    .reg_we(we), .reg_rdata(rdata)
  );

  // register file model
  assign rdata = mem[addr];
  always @(posedge clk) if (we) begin
    mem[addr] <= wdata;
    we_cnt    <= we_cnt + 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // shift n bits MSB first; returns bits seen on miso at rising edges
  task automatic bits(input logic [7:0] tx, input int n, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i > 7 - n; i--) begin
      mosi = tx[i];
      wclk(4);
      sclk = 1'b1;
      rx[i] = miso;
      if (miso_oe) oe_seen = 1'b1;
      wclk(4);
      sclk = 1'b0;
    end
  endtask

  task automatic cs_lo; csn = 1'b0; wclk(4); endtask
  task automatic cs_hi; wclk(6); csn = 1'b1; wclk(8); endtask

  task automatic wr_burst(input logic [6:0] a, input logic [7:0] d0, input int n);
    logic [7:0] r;
    cs_lo();
    bits({1'b1, a}, 8, r);
    for (int k = 0; k < n; k++) bits(d0 + 8'(k), 8, r);
    cs_hi();
  endtask

  task automatic rd_one(input logic [6:0] a, output logic [7:0] d);
    cs_lo();
    bits({1'b0, a}, 8, d);
    oe_seen = 1'b0;
    bits(8'h00, 8, d);
    cs_hi();
  endtask

  localparam int NV = 6;
  localparam logic [14:0] VEC [NV] = '{
    {7'h00, 8'hA5}, {7'h01, 8'h5A}, {7'h33, 8'hFF},
    {7'h40, 8'h00}, {7'h7F, 8'h81}, {7'h15, 8'h3C}
  };

  initial begin
    logic [7:0] r, b0, b1, b2;
    int         c0;
    for (int i = 0; i < 128; i++) mem[i] = 8'(i ^ 8'h6B);
    wclk(5);
    rst_n = 1'b1;
    wclk(5);
    chk("R9 addr", 32'(addr), 32'h0);
    chk("R9 we", 32'(we), 32'h0);
    chk("R9 oe", 32'(miso_oe), 32'h0);

    // table: single write then read back
    for (int v = 0; v < NV; v++) begin
      c0 = we_cnt;
      wr_burst(VEC[v][14:8], VEC[v][7:0], 1);
      chk("R4 one strobe per byte", 32'(we_cnt - c0), 32'd1);
      chk("R3 write lands", 32'(mem[VEC[v][14:8]]), 32'(VEC[v][7:0]));
      rd_one(VEC[v][14:8], r);
      chk("R2 R8 read data", 32'(r), 32'(VEC[v][7:0]));
      chk("R8 oe in read data", 32'(oe_seen), 32'd1);
    end

    // R8 oe not during write data or command
    cs_lo();
    oe_seen = 1'b0;
    bits(8'h90, 8, r);
    bits(8'h11, 8, r);
    chk("R8 oe low in write", 32'(oe_seen), 32'd0);
    cs_hi();

    // R5 R6 burst write across wrap
    c0 = we_cnt;
    wr_burst(7'h7E, 8'hC0, 3);
    chk("R4 burst strobes", 32'(we_cnt - c0), 32'd3);
    chk("R5 7E", 32'(mem[7'h7E]), 32'hC0);
    chk("R5 7F", 32'(mem[7'h7F]), 32'hC1);
    chk("R6 wrap 00", 32'(mem[7'h00]), 32'hC2);

    // R5 R6 burst read across wrap
    cs_lo();
    bits(8'h7E, 8, r);
    bits(8'h00, 8, b0);
    bits(8'h00, 8, b1);
    bits(8'h00, 8, b2);
    cs_hi();
    chk("R5 read 7E", 32'(b0), 32'hC0);
    chk("R5 read 7F", 32'(b1), 32'hC1);
    chk("R6 read wrap 00", 32'(b2), 32'hC2);

    // R7 partial byte discarded
    c0 = we_cnt;
    cs_lo();
    bits(8'h90, 8, r);
    bits(8'hFF, 5, r);
    cs_hi();
    chk("R7 no strobe", 32'(we_cnt - c0), 32'd0);
    chk("R7 reg kept", 32'(mem[7'h10]), 32'h11);

    // R1 activity with chip select high
    c0 = we_cnt;
    csn = 1'b1;
    bits(8'h85, 8, r);
    bits(8'hEE, 8, r);
    chk("R1 no strobe", 32'(we_cnt - c0), 32'd0);
    chk("R1 oe low", 32'(miso_oe), 32'd0);
    rd_one(7'h05, r);
    chk("R1 reg kept", 32'(r), 32'(8'h05 ^ 8'h6B));

    // R3 read command with bit7=0 does not write
    c0 = we_cnt;
    rd_one(7'h7F, r);
    chk("R3 read no strobe", 32'(we_cnt - c0), 32'd0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule